// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Sequencer

This block is the digital control core of a four-channel converter that samples all of its inputs at the same instant. A rising edge on the active-low start strobe puts every hold channel into hold together and latches which channels are to be converted. The latched channels are then converted one at a time, lowest index first. A stand-in conversion engine does the converting: a cycle counter that yields a test word for each channel, so that the sequencing can be built and checked without the analog side.

While the sequence runs the block raises a busy flag. After each single conversion it pulses an active-low completion strobe. When busy drops, all hold channels return to tracking. The channel subset comes either from four select pins or from a channel register that is written over the bus. A selector input picks between the two. Results are kept in conversion order and are read out over a 14-bit parallel port with chip-select and read strobes.

Top module: `simsamp_seq`

## Requirements
- R1: After reset, busy is 0, eoc_n is 1, hold is 0 and rd_data is 0.
- R2: A rising edge of start_n that is seen while idle sets busy and all hold bits to 1 on the next clock, i.e. at the clock edge where start_n is first sampled high after being sampled low.
- R3: The subset is taken from sel_pins when src_sw is 0 and from the channel register when src_sw is 1. Bit i selects channel i. The register loads din on every clock where cs_n and wr_n are both 0. Its reset value is 4'b1111.
- R4: The subset is latched when the sequence is accepted. Changing sel_pins or the register during a sequence does not alter that sequence.
- R5: Selected channels convert in ascending index order. Each conversion takes CONV_CYCLES clocks. eoc_n is low for exactly one clock, k*CONV_CYCLES clocks after the first busy-high clock, for the k-th conversion.
- R6: busy and all hold bits fall together, one clock after the last eoc_n pulse.
- R7: An empty subset gives busy high for exactly one clock and no eoc_n pulse.
- R8: A start_n rising edge seen while busy is 1 is ignored.
- R9: A result word is {channel index[1:0], tag[11:0]}. The tag is the number of sequences completed since reset, modulo 4096.
- R10: While cs_n and rd_n are both 0, rd_data shows the stored result at the read pointer; at all other times it is 0. The pointer advances when a read strobe ends and returns to the first result when a sequence is accepted. Results are returned in conversion order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low start strobe; the rising edge begins a sequence |
| sel_pins | input | 4 | Channel subset from pins |
| src_sw | input | 1 | 0: subset from pins, 1: subset from register |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe for the channel register |
| rd_n | input | 1 | Active-low read strobe |
| din | input | 4 | Channel register write data |
| busy | output | 1 | High while a sequence runs |
| eoc_n | output | 1 | Active-low pulse at the end of each conversion |
| hold | output | 4 | Per-channel hold (1) or track (0) |
| rd_data | output | 14 | Result read data |

## Verification
The assertions assume that start_n has been stable for at least one clock before it rises. They also assume that CONV_CYCLES is at least 2, so that two completion pulses can never touch. They treat a start edge during busy as noise that must leave the spacing of eoc_n unchanged. The stimulus holds every start_n level for a full clock, drives all inputs on the falling edge, and sends its ignored start pulses well inside a running sequence, never on the clock where busy falls.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_e;

endpackage

// File: rtl/ssq_chan_src.sv
module ssq_chan_src #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [NUM_CH-1:0] din,
  input  logic [NUM_CH-1:0] sel_pins,
  input  logic              src_sw,
  output logic [NUM_CH-1:0] mask
);

  logic [NUM_CH-1:0] chreg_q, chreg_d;
  logic              chreg_en;

  assign chreg_en = ~cs_n & ~wr_n;

  always_comb begin
    chreg_d = chreg_q;
    if (chreg_en) chreg_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chreg_q <= '1;
    else        chreg_q <= chreg_d;
  end

  assign mask = src_sw ? chreg_q : sel_pins;

endmodule

// File: rtl/ssq_tick.sv
module ssq_tick #(
  parameter int unsigned CONV_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);

  localparam int unsigned CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done = en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (done) cnt_d = '0;
    else if (en)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ssq_store.sv
module ssq_store #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned RES_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [RES_W-1:0] wdata,
  input  logic             rd_act,
  output logic [RES_W-1:0] rd_data
);

  localparam int unsigned PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [RES_W-1:0] mem [NUM_CH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic             rd_q;

  always_comb begin
    wptr_d = wptr_q;
    if (clr)        wptr_d = '0;
    else if (wr_en) wptr_d = wptr_q + 1'b1;
    rptr_d = rptr_q;
    if (clr)                 rptr_d = '0;
    else if (rd_q && !rd_act) rptr_d = rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      rd_q   <= rd_act;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= wdata;
  end

  assign rd_data = rd_act ? mem[rptr_q] : '0;

endmodule

// File: rtl/simsamp_seq.sv
module simsamp_seq
  import ssq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned RES_W       = 14,
  parameter int unsigned CONV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic [NUM_CH-1:0] sel_pins,
  input  logic              src_sw,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [NUM_CH-1:0] din,
  output logic              busy,
  output logic              eoc_n,
  output logic [NUM_CH-1:0] hold,
  output logic [RES_W-1:0]  rd_data
);

  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned TAG_W = RES_W - CH_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  sq_state_e         state_q, state_d;
  logic [NUM_CH-1:0] pend_q, pend_d, sel_mask, cur_bit;
  logic [CH_W-1:0]   cur_ch;
  logic [TAG_W-1:0]  seq_q, seq_d;
  logic              busy_q, busy_d, eoc_q, eoc_d;
  logic [NUM_CH-1:0] hold_q, hold_d;
  logic              start_q, start_edge, accept, conv_en, conv_done;
  logic [RES_W-1:0]  result;

  assign start_edge = start_n & ~start_q;
  assign accept     = start_edge && (state_q == SQ_IDLE);
  assign conv_en    = (state_q == SQ_RUN) && (pend_q != '0);

  // lowest pending channel goes first
  always_comb begin
    cur_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_q[i]) cur_ch = CH_W'(i);
    end
    cur_bit = '0;
    cur_bit[cur_ch] = 1'b1;
  end

  assign result = {cur_ch, seq_q};

  ssq_chan_src #(.NUM_CH(NUM_CH)) u_src (
    .clk(clk), .rst_n(rst_sn), .cs_n(cs_n), .wr_n(wr_n), .din(din),
    .sel_pins(sel_pins), .src_sw(src_sw), .mask(sel_mask)
  );

  ssq_tick #(.CONV_CYCLES(CONV_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_sn), .clr(accept), .en(conv_en), .done(conv_done)
  );

  ssq_store #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_store (
    .clk(clk), .rst_n(rst_sn), .clr(accept), .wr_en(conv_done),
    .wdata(result), .rd_act(~cs_n & ~rd_n), .rd_data(rd_data)
  );

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    seq_d   = seq_q;
    busy_d  = busy_q;
    hold_d  = hold_q;
    eoc_d   = 1'b1;
    unique case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          state_d = SQ_RUN;
          pend_d  = sel_mask;
          busy_d  = 1'b1;
          hold_d  = '1;
        end
      end
      SQ_RUN: begin
        if (pend_q == '0) begin
          state_d = SQ_IDLE;
          busy_d  = 1'b0;
          hold_d  = '0;
          seq_d   = seq_q + 1'b1;
        end else if (conv_done) begin
          pend_d = pend_q & ~cur_bit;
          eoc_d  = 1'b0;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= SQ_IDLE;
      pend_q  <= '0;
      seq_q   <= '0;
      busy_q  <= 1'b0;
      hold_q  <= '0;
      eoc_q   <= 1'b1;
      start_q <= 1'b1;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      seq_q   <= seq_d;
      busy_q  <= busy_d;
      hold_q  <= hold_d;
      eoc_q   <= eoc_d;
      start_q <= start_n;
    end
  end

  assign busy  = busy_q;
  assign eoc_n = eoc_q;
  assign hold  = hold_q;

endmodule

// File: rtl/ssq_chk.sv
module ssq_chk #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned CONV_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_n,
  input logic              busy,
  input logic              eoc_n,
  input logic [NUM_CH-1:0] hold
);

  logic        st_q;
  logic [31:0] gap_q, neoc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= 1'b1;
      gap_q  <= '0;
      neoc_q <= '0;
    end else begin
      st_q <= start_n;
      if (!busy)       gap_q <= '0;
      else if (!eoc_n) gap_q <= 32'd1;
      else             gap_q <= gap_q + 32'd1;
      if (!busy)       neoc_q <= '0;
      else if (!eoc_n) neoc_q <= neoc_q + 32'd1;
    end
  end

  // R2: an accepted start edge raises busy and holds every channel
  a_r2_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && !st_q && !busy) |=> (busy && (&hold)));

  // R6: hold follows busy
  a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    hold == {NUM_CH{busy}});

  // R5: completion pulse lasts one clock and lies inside busy
  a_r5_eoc_single: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_n |=> eoc_n);
  a_r5_eoc_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_n |-> busy);

  // R5, R8: pulses spaced by exactly one conversion time, untouched by starts
  a_r8_eoc_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_n |-> (gap_q == CONV_CYCLES));

  // R7: never more conversions than channels in one sequence
  a_r7_eoc_limit: assert property (@(posedge clk) disable iff (!rst_n)
    neoc_q <= NUM_CH);

endmodule

bind simsamp_seq ssq_chk #(.NUM_CH(NUM_CH), .CONV_CYCLES(CONV_CYCLES)) u_ssq_chk (
  .clk(clk), .rst_n(rst_n), .start_n(start_n), .busy(busy),
  .eoc_n(eoc_n), .hold(hold)
);

// File: tb/test_simsamp_seq.sv
module test_simsamp_seq;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n, start_n, src_sw, cs_n, wr_n, rd_n;
  logic [3:0]  sel_pins, din;
  logic        busy, eoc_n;
  logic [3:0]  hold;
  logic [13:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seq_m  = 0;
  logic [3:0] reg_m = 4'hF;

  always #2 clk = ~clk;

  simsamp_seq i_simsamp_seq (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .sel_pins(sel_pins),
    .src_sw(src_sw), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
    .busy(busy), .eoc_n(eoc_n), .hold(hold), .rd_data(rd_data)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

  // One full sequence with expected subset m; chg alters the selection mid-run
  // (R4), ign sends an extra start edge mid-run (R8).
  task automatic run_seq(input logic [3:0] m, input bit chg, input bit ign);
    int k_tot, k, bad_t, bad_h, last;
    int order[4];
    k_tot = 0;
    for (int i = 0; i < 4; i++) if (m[i]) begin order[k_tot] = i; k_tot++; end
    last = k_tot * N + 1;
    bad_t = 0; bad_h = 0;
    @(negedge clk) start_n = 1'b0;
    @(negedge clk) start_n = 1'b1;
    for (int j = 0; j <= last; j++) begin
      bit eb, bb;
      @(negedge clk);
      eb = (j > 0) && (j % N == 0) && (j / N <= k_tot);
      bb = (j < last);
      if (eoc_n !== !eb || busy !== bb) begin
        bad_t++;
        $display("  j=%0d eoc_n=%b busy=%b", j, eoc_n, busy);
      end
      if (hold !== {4{bb}}) bad_h++;
      if (chg && j == 2) begin
        sel_pins = ~sel_pins;
        cs_n = 1'b0; wr_n = 1'b0; din = ~reg_m; reg_m = ~reg_m;
      end
      if (chg && j == 3) begin cs_n = 1'b1; wr_n = 1'b1; end
      if (ign && j == 3) start_n = 1'b0;
      if (ign && j == 4) start_n = 1'b1;
    end
    chk(bad_t == 0, "R5/R6/R7/R8 eoc_n and busy timing", bad_t, 0);
    chk(bad_h == 0, "R2/R6 hold follows sequence", bad_h, 0);
    chk(rd_data == 14'd0, "R10 rd_data idle", rd_data, 0);
    for (int s = 0; s < k_tot; s++) begin
      logic [13:0] exp;
      exp = {2'(order[s]), 12'(seq_m)};
      cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      chk(rd_data == exp, "R9/R10 result in conversion order", rd_data, exp);
      cs_n = 1'b1; rd_n = 1'b1;
      @(negedge clk);
    end
    seq_m++;
  endtask

  initial begin
    rst_n = 1'b0; start_n = 1'b1; src_sw = 1'b0; cs_n = 1'b1;
    wr_n = 1'b1; rd_n = 1'b1; sel_pins = 4'h0; din = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 1'b0 && eoc_n == 1'b1 && hold == 4'h0 && rd_data == 14'd0,
        "R1 reset state", {busy, eoc_n, hold, rd_data}, 32'h40000);

    // R3 pins source, every subset; R7 empty subset included
    for (int m = 0; m < 16; m++) begin
      sel_pins = 4'(m);
      run_seq(4'(m), 1'b0, 1'b0);
    end

    // R3 register source: reset value all channels
    src_sw = 1'b1; sel_pins = 4'h0;
    run_seq(4'hF, 1'b0, 1'b0);

    // R3 register writes
    for (int m = 0; m < 16; m += 5) begin
      @(negedge clk) begin cs_n = 1'b0; wr_n = 1'b0; din = 4'(m); end
      @(negedge clk) begin cs_n = 1'b1; wr_n = 1'b1; end
      reg_m = 4'(m);
      run_seq(4'(m), 1'b0, 1'b0);
    end

    // R4 mid-sequence change, register source then pins source
    @(negedge clk) begin cs_n = 1'b0; wr_n = 1'b0; din = 4'h6; end
    @(negedge clk) begin cs_n = 1'b1; wr_n = 1'b1; end
    reg_m = 4'h6;
    run_seq(4'h6, 1'b1, 1'b0);
    chk(1'b1, "R4 register source sequence done", 0, 0);
    src_sw = 1'b0; sel_pins = 4'h9;
    run_seq(4'h9, 1'b1, 1'b0);

    // R8 start edge during busy ignored
    sel_pins = 4'h5;
    run_seq(4'h5, 1'b0, 1'b1);
    sel_pins = 4'h8;
    run_seq(4'h8, 1'b0, 1'b1);

    summary();
    $finish;
  end

endmodule